// File: doc/BRIEF.md
# Burst-Clock PCM Serial Port

This block moves one 8-bit PCM sample in each direction per frame over a serial link made of a bit clock, a frame sync, a serial input and a serial output. A frame nominally repeats every 125 µs. The bit clock may run continuously, anywhere from 64 kHz to 2048 kHz, or it may arrive as a short burst of edges each frame. The first rising bit-clock edge that sees a fresh sync is bit clock 1. Clocks 1 to 8 carry the data, most significant bit first. The ninth clock tells the core behind the port that a sample is ready, so a burst needs at least nine edges.

A mode input selects 64 kHz operation. In that mode eight clocks make a whole frame, and the falling edge of clock 8 gives the ready strobe in place of the ninth edge. A sync that reappears before a frame has its full clock count gives an error pulse, and that frame produces no strobe. By default the receive side has its own bit clock and sync. A parameter can tie it to the transmit pair instead.

Bit clock, sync and serial data are sampled on the fast system clock and must be synchronous to it. Every output is registered and moves one system clock after the edge that caused it. The pad's tri-state buffer sits outside the block and is driven from the output-enable port.

Top module: `pcm_burst_port`

## Requirements
- R1: While reset is asserted, pcm_oe, tx_start, rx_start, tx_err and rx_err are 0 and rx_sample is 0.
- R2: A frame starts on a rising bit-clock edge that samples sync high when sync was low at the previous rising edge. A sync held high across later rising edges, up to one less than the burst length, does not restart the frame.
- R3: On bit clock 1, tx_sample is captured and its bit 7 appears on pcm_out. Rising edges 2 to 8 present bits 6 down to 0 in turn.
- R4: pcm_oe rises with bit clock 1 and falls on the ninth rising edge of the frame. It stays 0 outside that window.
- R5: pcm_in is sampled on the falling edges of bit clocks 1 to 8, and the first bit becomes bit 7. rx_sample updates only in the cycle where rx_start is 1, and it is held otherwise.
- R6: With mode64=0, each direction pulses its strobe (tx_start or rx_start) for one system clock after the ninth rising edge. Further clocks in the same burst have no effect.
- R7: With mode64=1, the strobe follows the falling edge of bit clock 8, and no ninth clock is needed. With mode64=0, an 8-clock frame gives no strobe.
- R8: A frame start that comes before the previous frame reached its required count (9 edges, or 8 in 64 kHz mode) pulses that direction's error output for one cycle. The short frame gives no strobe and leaves rx_sample unchanged, and the new frame proceeds normally.
- R9: With SPLIT_CLK=1, the receive side is framed only by rx_bclk and rx_sync. Activity on the receive pair leaves pcm_oe and tx_start untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial interface |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 selects 8-clock frames (64 kHz operation) |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_sync | input | 1 | Transmit frame sync |
| rx_bclk | input | 1 | Receive bit clock (used when SPLIT_CLK=1) |
| rx_sync | input | 1 | Receive frame sync (used when SPLIT_CLK=1) |
| pcm_in | input | 1 | Serial receive data |
| tx_sample | input | W | Parallel sample to transmit |
| pcm_out | output | 1 | Serial transmit data, valid while pcm_oe is 1 |
| pcm_oe | output | 1 | Enable for the external tri-state driver of pcm_out |
| tx_start | output | 1 | One-cycle transmit-frame-complete strobe |
| tx_err | output | 1 | One-cycle pulse on a truncated transmit frame |
| rx_sample | output | W | Last complete received sample |
| rx_start | output | 1 | One-cycle receive-frame-complete strobe |
| rx_err | output | 1 | One-cycle pulse on a truncated receive frame |

## Verification
The bench sends a 12-clock burst whose sync stays high for eight clocks. A design that restarted on a level sync would shift the sample twice and never strobe. It cuts a frame short at five clocks and checks that the error pulse appears, no strobe fires and rx_sample keeps its old value. A design that strobed on the next sync would publish half a sample. It runs 8-clock frames with 64 kHz mode both on and off, which catches a design that waits for a ninth edge when none comes, or strobes early in normal mode. It also drives the two directions apart, so that receive framing taken from the transmit clock would lose the receive sample.

// File: rtl/pcm_burst_port.sv
module pcm_burst_port #(
  parameter int W = 8,
  parameter bit SPLIT_CLK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode64,
  input  logic         tx_bclk,
  input  logic         tx_sync,
  input  logic         rx_bclk,
  input  logic         rx_sync,
  input  logic         pcm_in,
  input  logic [W-1:0] tx_sample,
  output logic         pcm_out,
  output logic         pcm_oe,
  output logic         tx_start,
  output logic         tx_err,
  output logic [W-1:0] rx_sample,
  output logic         rx_start,
  output logic         rx_err
);

  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] LAST = CW'(W);
  localparam logic [CW-1:0] TRIG = CW'(W + 1);

  logic [1:0]    bclk_in, sync_in, bclk_q, sync_last;
  logic [1:0]    rise, fall, first, done, strb, errp;
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] need;
  logic [W-1:0]  tx_sh, rx_sh, rx_nx;

  assign bclk_in[0] = tx_bclk;
  assign sync_in[0] = tx_sync;

  generate
    if (SPLIT_CLK) begin : g_split
      assign bclk_in[1] = rx_bclk;
      assign sync_in[1] = rx_sync;
    end else begin : g_shared
      assign bclk_in[1] = tx_bclk;
      assign sync_in[1] = tx_sync;
    end
  endgenerate

  assign need = mode64 ? LAST : TRIG;

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      rise[d]  = bclk_in[d] & ~bclk_q[d];
      fall[d]  = ~bclk_in[d] & bclk_q[d];
      first[d] = rise[d] & sync_in[d] & ~sync_last[d];
      done[d]  = mode64 ? (fall[d] && cnt[d] == LAST)
                        : (rise[d] && !first[d] && cnt[d] == LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= '0;
      sync_last <= '0;
      strb      <= '0;
      errp      <= '0;
      for (int d = 0; d < 2; d++) cnt[d] <= '0;
    end else begin
      bclk_q <= bclk_in;
      strb   <= done;
      for (int d = 0; d < 2; d++) begin
        errp[d] <= first[d] && cnt[d] != '0 && cnt[d] < need;
        if (rise[d]) sync_last[d] <= sync_in[d];
        if (first[d])
          cnt[d] <= CW'(1);
        else if (rise[d] && cnt[d] != '0 && cnt[d] != TRIG)
          cnt[d] <= cnt[d] + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      pcm_oe <= 1'b0;
    end else if (first[0]) begin
      tx_sh  <= tx_sample;
      pcm_oe <= 1'b1;
    end else if (rise[0]) begin
      if (cnt[0] != '0 && cnt[0] < LAST)
        tx_sh <= {tx_sh[W-2:0], 1'b0};
      else if (cnt[0] == LAST)
        pcm_oe <= 1'b0;
    end
  end

  assign pcm_out = tx_sh[W-1];
  assign rx_nx   = {rx_sh[W-2:0], pcm_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      rx_sample <= '0;
    end else begin
      if (fall[1] && cnt[1] != '0 && cnt[1] <= LAST)
        rx_sh <= rx_nx;
      if (done[1])
        rx_sample <= mode64 ? rx_nx : rx_sh;
    end
  end

  assign tx_start = strb[0];
  assign rx_start = strb[1];
  assign tx_err   = errp[0];
  assign rx_err   = errp[1];

endmodule

// File: rtl/pcm_burst_port_chk.sv
module pcm_burst_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_bclk,
  input logic         tx_sync,
  input logic         pcm_out,
  input logic         pcm_oe,
  input logic         tx_start,
  input logic         tx_err,
  input logic         rx_start,
  input logic [W-1:0] rx_sample
);

  AST_TX_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R6

  AST_RX_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> !rx_start); // R6

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> !tx_start); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_sample) |-> rx_start); // R5

  AST_OE_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_oe) |-> $past(tx_sync) && $past(tx_bclk)); // R4

  AST_OUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pcm_out) |-> $past(tx_bclk) && !$past(tx_bclk, 2)); // R3

endmodule

bind pcm_burst_port pcm_burst_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bclk(tx_bclk), .tx_sync(tx_sync),
  .pcm_out(pcm_out), .pcm_oe(pcm_oe), .tx_start(tx_start), .tx_err(tx_err),
  .rx_start(rx_start), .rx_sample(rx_sample)
);

// File: tb/pcm_burst_port_test.sv
module pcm_burst_port_test;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, mode64 = 1'b0;
  logic tx_bclk = 1'b0, tx_sync = 1'b0, rx_bclk = 1'b0, rx_sync = 1'b0, pcm_in = 1'b0;
  logic [7:0] tx_sample = '0;
  logic pcm_out, pcm_oe, tx_start, tx_err, rx_start, rx_err;
  logic [7:0] rx_sample;

  int checks = 0, fails = 0;
  int tx_cnt = 0, txe_cnt = 0, rxe_cnt = 0;
  bit tx_open = 0, rx_open = 0, done_flag = 0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  pcm_burst_port uut (
    .clk(clk), .rst_n(rst_n), .mode64(mode64),
    .tx_bclk(tx_bclk), .tx_sync(tx_sync), .rx_bclk(rx_bclk), .rx_sync(rx_sync),
    .pcm_in(pcm_in), .tx_sample(tx_sample),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .tx_start(tx_start), .tx_err(tx_err),
    .rx_sample(rx_sample), .rx_start(rx_start), .rx_err(rx_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_start) begin
        if (expq.size() == 0) chk(1'b0, "R8 unexpected rx strobe", 32'(rx_sample), 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(rx_sample == e, "R5 rx sample", 32'(rx_sample), 32'(e));
        end
      end
      if (tx_start) tx_cnt++;
      if (tx_err) txe_cnt++;
      if (rx_err) rxe_cnt++;
    end
  end

  task automatic frame(input bit do_tx, input bit do_rx, input int nclk, input int syncw,
                       input logic [7:0] txd, input logic [7:0] rxd);
    int t0 = tx_cnt, te0 = txe_cnt, re0 = rxe_cnt;
    int need = mode64 ? 8 : 9;
    bit full = (nclk >= need);
    @(negedge clk);
    if (do_tx) tx_sample = txd;
    if (do_rx && full) expq.push_back(rxd);
    for (int i = 1; i <= nclk; i++) begin
      @(negedge clk);
      if (do_tx) begin tx_bclk = 1'b1; tx_sync = (i <= syncw); end
      if (do_rx) begin
        rx_bclk = 1'b1; rx_sync = (i <= syncw);
        pcm_in = (i <= 8) ? rxd[8-i] : 1'b0;
      end
      repeat (H) @(negedge clk);
      if (do_tx && i <= 8) begin
        chk(pcm_oe == 1'b1, "R4 oe in slot", 32'(pcm_oe), 1);
        chk(pcm_out == txd[8-i], "R3 tx bit", 32'(pcm_out), 32'(txd[8-i]));
      end
      if (do_tx && i == 9) chk(pcm_oe == 1'b0, "R4 oe after slot 8", 32'(pcm_oe), 0);
      if (!do_tx && !mode64) chk(pcm_oe == 1'b0, "R9 oe idle", 32'(pcm_oe), 0);
      tx_bclk = 1'b0; rx_bclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    tx_sync = 1'b0; rx_sync = 1'b0;
    repeat (6) @(negedge clk);
    if (do_tx) begin
      chk(tx_cnt - t0 == int'(full), "R6/R7 tx strobe count", 32'(tx_cnt - t0), 32'(full));
      chk(txe_cnt - te0 == int'(tx_open), "R8 tx err", 32'(txe_cnt - te0), 32'(tx_open));
      tx_open = !full;
    end else chk(tx_cnt == t0, "R9 tx strobe idle", 32'(tx_cnt - t0), 0);
    if (do_rx) begin
      chk(rxe_cnt - re0 == int'(rx_open), "R8 rx err", 32'(rxe_cnt - re0), 32'(rx_open));
      rx_open = !full;
    end
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(pcm_oe == 0 && tx_start == 0 && rx_start == 0, "R1 reset outputs",
        32'({pcm_oe, tx_start, rx_start}), 0);
    chk(tx_err == 0 && rx_err == 0 && rx_sample == 0, "R1 reset err/sample",
        32'({tx_err, rx_err, rx_sample}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    frame(1, 1, 9, 1, 8'hA5, 8'h3C);
    frame(1, 1, 12, 8, 8'h81, 8'h7E);   // R2 long sync, R6 extra clocks
    frame(1, 1, 9, 8, 8'h01, 8'hFF);
    frame(1, 1, 5, 2, 8'h55, 8'hAA);    // R8 truncated
    chk(rx_sample == 8'hFF, "R8 rx_sample held", 32'(rx_sample), 32'hFF);
    frame(1, 1, 10, 1, 8'h0F, 8'hF0);
    frame(0, 1, 9, 1, 8'h00, 8'h96);    // R9 receive only
    frame(1, 0, 9, 1, 8'hC3, 8'h00);
    chk(rx_sample == 8'h96, "R9 rx_sample kept", 32'(rx_sample), 32'h96);

    mode64 = 1'b1;
    frame(1, 1, 8, 1, 8'h12, 8'h34);    // R7
    frame(1, 1, 8, 3, 8'h5A, 8'hA5);
    frame(1, 1, 7, 1, 8'hE7, 8'h18);    // R8 short in 64 kHz mode
    frame(1, 1, 8, 1, 8'h6B, 8'hB6);
    frame(1, 1, 9, 1, 8'h24, 8'h42);
    mode64 = 1'b0;
    frame(1, 1, 8, 1, 8'h99, 8'h66);    // R7 no strobe at 8 in normal mode
    frame(1, 1, 9, 2, 8'hC0, 8'h03);

    chk(expq.size() == 0, "R5 all samples seen", 32'(expq.size()), 0);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule